// File: doc/BRIEF.md
# Driver Precompensation Strength Controller

This block decides, for every output signal of a parallel bus transmitter and for every transfer period, whether the pad driver should run at full or at reduced strength. Intersymbol interference is reduced by boosting only the first period after a level change: a bit that has just switched is driven hard, and a bit that repeats its previous level is driven softly. The covered signals are the request strobe, the acknowledge strobe, the parity bits and the data bits. Each bit is judged only on its own history.

The transmit path presents the value about to be driven on each signal and pulses a period enable once per transfer period. On that edge the block compares each new value with the value it last recorded for that bit. It then registers a strength select and records the new value. Precompensation is active only while the feature enable is set and the transmitter is in its fastest transfer mode. In any other case every select reads full strength. The analog drivers and slew control sit outside this block.

Top module: `pcomp_strength_ctrl`

## Requirements
- R1: A strength select output of 1 means full drive and 0 means reduced drive. While active, after a period enable on which a bit's new value differs from its recorded value, that bit's select is 1 from the next clock cycle.
- R2: While active, after a period enable on which a bit's new value equals its recorded value, that bit's select is 0 from the next clock cycle.
- R3: Between period enables, selects and recorded values hold. A reduced select therefore stays 0 until a period enable brings a change in either direction, rising or falling.
- R4: Each of the request, acknowledge, PAR_W parity and DATA_W data bits has its own select, decided independently of all the other bits.
- R5: Precompensation is active only when `pcomp_en` = 1 and `fast_mode` = 1. Otherwise every select output is 1 in the same cycle, without waiting for a period enable.
- R6: Recorded values update on every period enable, including while inactive. After re-activation, comparisons use the last value presented.
- R7: Reset sets every select to 1 and every recorded value to 0. The first active period therefore reduces bits presented as 0 and boosts bits presented as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_en | input | 1 | One-cycle pulse per transfer period |
| pcomp_en | input | 1 | Precompensation feature enable |
| fast_mode | input | 1 | Transmitter is in the fastest transfer mode |
| req_nxt | input | 1 | Next request value to drive |
| ack_nxt | input | 1 | Next acknowledge value to drive |
| par_nxt | input | PAR_W | Next parity values to drive |
| dat_nxt | input | DATA_W | Next data values to drive |
| req_strong | output | 1 | Request strength select (1 = full) |
| ack_strong | output | 1 | Acknowledge strength select (1 = full) |
| par_strong | output | PAR_W | Per-bit parity strength selects |
| dat_strong | output | DATA_W | Per-bit data strength selects |

## Verification
A decision taken on a period enable reaches the select outputs exactly one clock later, when the lane register updates. The mode override acts on the outputs in the same cycle with no register on its path. The bench drives each stimulus on a falling edge and applies a single period enable. For registered results it samples on the following falling edge, after the rising edge that captures them. For the mode override it samples a short delay after changing the enables, with no rising edge in between. The hold checks remove the period enable, change every next value, and then confirm that the outputs remain unchanged across several rising edges.

// File: rtl/pcomp_pkg.sv
package pcomp_pkg;

  // Total lanes: request, acknowledge, parity bits, data bits.
  function automatic int lane_total(input int par_w, input int dat_w);
    return 2 + par_w + dat_w;
  endfunction

  // A lane needs the boost when its next value differs from the recorded one.
  function automatic logic needs_boost(input logic nxt_v, input logic rec_v);
    return nxt_v ^ rec_v;
  endfunction

  // Full strength is forced whenever precompensation is not in force.
  function automatic logic lane_select(input logic boost_v, input logic active_v);
    return boost_v | ~active_v;
  endfunction

endpackage

// File: rtl/pcomp_lane.sv
module pcomp_lane
  import pcomp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic nxt,
  output logic boost
);

  logic rec_q;
  logic boost_q;
  logic change_w;

  assign change_w = needs_boost(nxt, rec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q   <= 1'b0;
      boost_q <= 1'b1;
    end else if (tick) begin
      rec_q   <= nxt;
      boost_q <= change_w;
    end
  end

  assign boost = boost_q;

  // R1: a changed bit is boosted for the following period
  assert_boost_on_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (nxt != rec_q) |=> boost);

  // R2: a repeated bit drops to reduced drive
  assert_weak_on_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (nxt == rec_q) |=> !boost);

  // R3: nothing moves between period enables
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(boost) && $stable(rec_q));

  // R6: the record follows the presented value on every enable
  assert_record_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> rec_q == $past(nxt));

endmodule

// File: rtl/pcomp_gate.sv
module pcomp_gate
  import pcomp_pkg::*;
#(
  parameter int N = 20
) (
  input  logic         pcomp_en,
  input  logic         fast_mode,
  input  logic [N-1:0] boost_vec,
  output logic         active,
  output logic [N-1:0] strong_vec
);

  assign active = pcomp_en & fast_mode;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign strong_vec[i] = lane_select(boost_vec[i], active);
  end

endmodule

// File: rtl/pcomp_strength_ctrl.sv
module pcomp_strength_ctrl
  import pcomp_pkg::*;
#(
  parameter int PAR_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_en,
  input  logic              pcomp_en,
  input  logic              fast_mode,
  input  logic              req_nxt,
  input  logic              ack_nxt,
  input  logic [PAR_W-1:0]  par_nxt,
  input  logic [DATA_W-1:0] dat_nxt,
  output logic              req_strong,
  output logic              ack_strong,
  output logic [PAR_W-1:0]  par_strong,
  output logic [DATA_W-1:0] dat_strong
);

  localparam int N      = lane_total(PAR_W, DATA_W);
  localparam int PAR_LO = 2;
  localparam int DAT_LO = 2 + PAR_W;

  logic [N-1:0] nxt_vec;
  logic [N-1:0] boost_vec;
  logic [N-1:0] strong_vec;
  logic         active;

  // Lane order: 0 request, 1 acknowledge, then parity, then data.
  assign nxt_vec = {dat_nxt, par_nxt, ack_nxt, req_nxt};

  for (genvar i = 0; i < N; i++) begin : g_lane
    pcomp_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (period_en),
      .nxt   (nxt_vec[i]),
      .boost (boost_vec[i])
    );
  end

  pcomp_gate #(.N(N)) u_gate (
    .pcomp_en   (pcomp_en),
    .fast_mode  (fast_mode),
    .boost_vec  (boost_vec),
    .active     (active),
    .strong_vec (strong_vec)
  );

  assign req_strong = strong_vec[0];
  assign ack_strong = strong_vec[1];
  assign par_strong = strong_vec[PAR_LO +: PAR_W];
  assign dat_strong = strong_vec[DAT_LO +: DATA_W];

  // R5: inactive means every select reads full strength
  assert_full_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcomp_en && fast_mode) |-> (&{req_strong, ack_strong, par_strong, dat_strong}));

  // R7: leaving reset, every lane still holds the full-strength state
  assert_reset_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&boost_vec));

  // R4: an active lane that saw no enable keeps its select
  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_en && active && $past(active) |=> $stable(strong_vec) || !active);

endmodule

// File: tb/tb_pcomp_strength_ctrl.sv
module tb_pcomp_strength_ctrl;

  localparam int PAR_W  = 2;
  localparam int DATA_W = 16;
  localparam int W      = 2 + PAR_W + DATA_W;
  localparam int NV     = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_en = 1'b0;
  logic pcomp_en = 1'b0;
  logic fast_mode = 1'b0;
  logic req_nxt = 1'b0;
  logic ack_nxt = 1'b0;
  logic [PAR_W-1:0]  par_nxt = '0;
  logic [DATA_W-1:0] dat_nxt = '0;
  logic req_strong, ack_strong;
  logic [PAR_W-1:0]  par_strong;
  logic [DATA_W-1:0] dat_strong;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pcomp_strength_ctrl #(.PAR_W(PAR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .period_en(period_en),
    .pcomp_en(pcomp_en), .fast_mode(fast_mode),
    .req_nxt(req_nxt), .ack_nxt(ack_nxt), .par_nxt(par_nxt), .dat_nxt(dat_nxt),
    .req_strong(req_strong), .ack_strong(ack_strong),
    .par_strong(par_strong), .dat_strong(dat_strong)
  );

  // Layout {data, parity, ack, req}; 1 = full strength.
  // Vector: {pcomp_en, fast_mode, stimulus[19:0], expected[19:0]}
  localparam logic [41:0] VEC [NV] = '{
    {2'b11, 20'h00000, 20'h00000},  // R7 first period, all zero -> reduced
    {2'b11, 20'h00001, 20'h00001},  // R1 req rises
    {2'b11, 20'h00001, 20'h00000},  // R2 req repeats
    {2'b11, 20'h00000, 20'h00001},  // R3 req falls -> full again
    {2'b11, 20'hA5A5C, 20'hA5A5C},  // R4 mixed lanes change
    {2'b11, 20'hA5A5C, 20'h00000},  // R2 all repeat
    {2'b11, 20'h5A5A3, 20'hFFFFF},  // R1 all invert
    {2'b10, 20'h5A5A3, 20'hFFFFF},  // R5 slow mode
    {2'b01, 20'h00FF0, 20'hFFFFF},  // R5 feature off
    {2'b11, 20'h00FF0, 20'h00000},  // R6 record kept while off
    {2'b11, 20'h0F0F2, 20'h0FF02}   // R4 independent lanes
  };

  function automatic logic [W-1:0] outs();
    return {dat_strong, par_strong, ack_strong, req_strong};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [W-1:0] s);
    {dat_nxt, par_nxt, ack_nxt, req_nxt} = s;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    pcomp_en = 1'b1;
    fast_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset full", outs(), '1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset full", outs(), '1);

    for (int i = 0; i < NV; i++) begin
      pcomp_en  = VEC[i][41];
      fast_mode = VEC[i][40];
      present(VEC[i][39:20]);
      period_en = 1'b1;
      @(negedge clk);
      period_en = 1'b0;
      check($sformatf("R1/R2 vector %0d", i), outs(), VEC[i][19:0]);
    end

    // Hold between enables: last output 0FF02, record 0F0F2.
    present(20'hFFFFF);
    repeat (3) @(negedge clk);
    check("R3 hold without enable", outs(), 20'h0FF02);

    // Mode override is immediate.
    fast_mode = 1'b0;
    #1;
    check("R5 slow mode immediate", outs(), 20'hFFFFF);
    fast_mode = 1'b1;
    #1;
    check("R5 re-activate restores", outs(), 20'h0FF02);

    // Record must be 0F0F2: present it again -> all reduced.
    @(negedge clk);
    present(20'h0F0F2);
    period_en = 1'b1;
    @(negedge clk);
    period_en = 1'b0;
    check("R6 record unchanged by hold", outs(), 20'h00000);

    // Single data bit toggles; only that lane boosted.
    present(20'h8F0F2);
    period_en = 1'b1;
    @(negedge clk);
    period_en = 1'b0;
    check("R4 single data lane", outs(), 20'h80000);

    // Mid-run reset returns to full and zero record.
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid-run reset", outs(), '1);
    rst_n = 1'b1;
    present(20'h00004);
    period_en = 1'b1;
    @(negedge clk);
    period_en = 1'b0;
    check("R7 record cleared", outs(), 20'h00004);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule